// File: doc/BRIEF.md
# Time-Wheel Bus Arbiter with Deferred Table Swap

This block shares one bus among a fixed set of masters by time division. A wheel of one slot per master turns without end, always in ascending master order. Each slot grants the bus to its master for a programmed number of clock cycles. Software sets these lengths directly in cycles, not as shares of bandwidth.

Software programs a shadow copy of the slot table. Each configuration write carries a master index and a length. The shadow entry for any index can be read back at once. A load command arms the shadow copy. The arbiter adopts it only at the next round boundary, so a round never changes part way through. An entry that was not rewritten keeps its earlier value, because the shadow copy persists between loads. When the new table takes over, the arbiter raises a one-cycle interrupt so that every core learns of the change.

A slot of length zero is skipped with no lost cycle. A table that is all zero grants nothing, and each of its idle cycles counts as a round boundary.

Top module: `tdma_wheel_arbiter`

## Requirements
- R1: Slots run in ascending master order 0, 1, ... N-1 and then wrap to 0. Each round repeats the active table for as long as no swap takes place.
- R2: A configuration write (`cfg_wr_i`=1) sets the shadow length of master `cfg_id_i` to `cfg_len_i`. A master with length L holds its slot for exactly L consecutive clock cycles.
- R3: `cfg_rd_len_o` shows the shadow length of master `cfg_rd_id_i` combinationally. A write is visible there from the cycle after it.
- R4: A one-cycle pulse on `load_i` arms a swap. The shadow table becomes active only at the boundary after the current round's last slot. Without a load, the active table never changes.
- R5: A master whose shadow entry was not written since the last swap keeps its previous length in the new table.
- R6: A write accepted after the load but before the swap boundary is included in that swap. This also holds for a write in the boundary cycle itself.
- R7: `irq_o` is high for exactly one cycle: the first cycle in which the new table governs the grant.
- R8: A slot of length zero is skipped in the same cycle, so the grant passes straight to the next non-zero slot with no idle cycle.
- R9: If every active length is zero, no grant is asserted. Each idle cycle is a round boundary, so a loaded table takes effect two cycles after the load pulse.
- R10: `grant_o` is one-hot or zero. Bit i is high only while master i owns the current slot and `req_i[i]` is high. A request from a master that does not own the slot has no effect.
- R11: After reset, both tables hold DEF_LEN for every master, no swap is armed, and master 0 owns the first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master bus request |
| grant_o | output | N_MASTERS | One-hot bus grant |
| irq_o | output | 1 | One-cycle pulse when a new table takes effect |
| cfg_wr_i | input | 1 | Shadow-table write strobe |
| cfg_id_i | input | ID_W | Master index for the write |
| cfg_len_i | input | LEN_W | Slot length in cycles for the write |
| load_i | input | 1 | Arm the shadow table for the next boundary |
| cfg_rd_id_i | input | ID_W | Master index for readback |
| cfg_rd_len_o | output | LEN_W | Shadow length of the indexed master |

## Verification
Grant and readback follow the registered state combinationally, so they are sampled just after the falling edge of the cycle concerned. `irq_o` and the first grant of a new table appear together, one cycle after the last slot of the old round. A load has its first effect at the round boundary it precedes, or two cycles after the pulse when the table is all zero. The bench aligns itself to a round start, or to the interrupt, and then compares every following cycle against a grant sequence built from the expected table. This catches a lost cycle, an early swap or a repeated interrupt at the exact cycle where it occurs.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
    parameter int unsigned TDMA_MASTERS = 4;
    parameter int unsigned TDMA_LEN_W   = 8;
    parameter int unsigned TDMA_DEF_LEN = 4;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tdma_slot_table.sv
module tdma_slot_table #(
    parameter int unsigned N_MASTERS = tdma_pkg::TDMA_MASTERS,
    parameter int unsigned LEN_W     = tdma_pkg::TDMA_LEN_W,
    parameter int unsigned DEF_LEN   = tdma_pkg::TDMA_DEF_LEN,
    localparam int unsigned ID_W     = tdma_pkg::idx_width(N_MASTERS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             wr_i,
    input  logic [ID_W-1:0]                  wr_id_i,
    input  logic [LEN_W-1:0]                 wr_len_i,
    input  logic                             swap_i,
    input  logic [ID_W-1:0]                  rd_id_i,
    output logic [LEN_W-1:0]                 rd_len_o,
    output logic [N_MASTERS-1:0][LEN_W-1:0]  act_o,
    output logic [N_MASTERS-1:0][LEN_W-1:0]  pend_nxt_o
);
    logic [N_MASTERS-1:0][LEN_W-1:0] pend_d, pend_q;
    logic [N_MASTERS-1:0][LEN_W-1:0] act_d, act_q;

    // shadow copy: persists across loads, so unwritten entries carry over
    always_comb begin
        pend_d = pend_q;
        if (wr_i && (int'(wr_id_i) < int'(N_MASTERS))) begin
            pend_d[wr_id_i] = wr_len_i;
        end
    end

    // active copy takes the merged shadow, including a same-cycle write
    always_comb begin
        act_d = swap_i ? pend_d : act_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(N_MASTERS); i++) begin
                pend_q[i] <= LEN_W'(DEF_LEN);
                act_q[i]  <= LEN_W'(DEF_LEN);
            end
        end else begin
            pend_q <= pend_d;
            act_q  <= act_d;
        end
    end

    assign rd_len_o   = (int'(rd_id_i) < int'(N_MASTERS)) ? pend_q[rd_id_i] : '0;
    assign act_o      = act_q;
    assign pend_nxt_o = pend_d;
endmodule

// File: rtl/tdma_wheel_timer.sv
module tdma_wheel_timer #(
    parameter int unsigned N_MASTERS = tdma_pkg::TDMA_MASTERS,
    parameter int unsigned LEN_W     = tdma_pkg::TDMA_LEN_W,
    parameter int unsigned DEF_LEN   = tdma_pkg::TDMA_DEF_LEN,
    localparam int unsigned ID_W     = tdma_pkg::idx_width(N_MASTERS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             load_i,
    input  logic [N_MASTERS-1:0][LEN_W-1:0]  act_i,
    input  logic [N_MASTERS-1:0][LEN_W-1:0]  pend_nxt_i,
    output logic [ID_W-1:0]                  owner_o,
    output logic                             live_o,
    output logic                             swap_o,
    output logic                             arm_o,
    output logic                             irq_o
);
    typedef struct packed {
        logic [ID_W-1:0]  cur;
        logic [LEN_W-1:0] cnt;
        logic             live;
        logic             arm;
        logic             irq;
    } wheel_t;

    localparam logic RST_LIVE = (DEF_LEN != 0);

    wheel_t st_d, st_q;

    logic                            expire;
    logic                            rest_hit;
    logic [ID_W-1:0]                 rest_idx;
    logic                            head_hit;
    logic [ID_W-1:0]                 head_idx;
    logic                            round_end;
    logic                            swap;
    logic [N_MASTERS-1:0][LEN_W-1:0] next_tbl;

    // later non-zero slot in the running round
    always_comb begin
        rest_hit = 1'b0;
        rest_idx = '0;
        for (int i = 0; i < int'(N_MASTERS); i++) begin
            if (!rest_hit && (i > int'(st_q.cur)) && (act_i[i] != '0)) begin
                rest_hit = 1'b1;
                rest_idx = ID_W'(i);
            end
        end
    end

    assign expire    = !st_q.live || (st_q.cnt == LEN_W'(1));
    assign round_end = expire && (!st_q.live || !rest_hit);
    assign swap      = round_end && st_q.arm;
    assign next_tbl  = swap ? pend_nxt_i : act_i;

    // first non-zero slot of the round that follows
    always_comb begin
        head_hit = 1'b0;
        head_idx = '0;
        for (int i = 0; i < int'(N_MASTERS); i++) begin
            if (!head_hit && (next_tbl[i] != '0)) begin
                head_hit = 1'b1;
                head_idx = ID_W'(i);
            end
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = swap;
        st_d.arm = (st_q.arm && !swap) || load_i;
        if (!expire) begin
            st_d.cnt = st_q.cnt - LEN_W'(1);
        end else if (!round_end) begin
            st_d.cur = rest_idx;
            st_d.cnt = act_i[rest_idx];
        end else if (head_hit) begin
            st_d.cur  = head_idx;
            st_d.cnt  = next_tbl[head_idx];
            st_d.live = 1'b1;
        end else begin
            st_d.cur  = '0;
            st_d.cnt  = '0;
            st_d.live = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cur  <= '0;
            st_q.cnt  <= LEN_W'(DEF_LEN);
            st_q.live <= RST_LIVE;
            st_q.arm  <= 1'b0;
            st_q.irq  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_o = st_q.cur;
    assign live_o  = st_q.live;
    assign swap_o  = swap;
    assign arm_o   = st_q.arm;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/tdma_grant_decode.sv
module tdma_grant_decode #(
    parameter int unsigned N_MASTERS = tdma_pkg::TDMA_MASTERS,
    localparam int unsigned ID_W     = tdma_pkg::idx_width(N_MASTERS)
) (
    input  logic [ID_W-1:0]      owner_i,
    input  logic                 live_i,
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] grant_o
);
    for (genvar g = 0; g < int'(N_MASTERS); g++) begin : g_lane
        assign grant_o[g] = live_i && (owner_i == ID_W'(g)) && req_i[g];
    end
endmodule

// File: rtl/tdma_wheel_arbiter.sv
module tdma_wheel_arbiter #(
    parameter int unsigned N_MASTERS = tdma_pkg::TDMA_MASTERS,
    parameter int unsigned LEN_W     = tdma_pkg::TDMA_LEN_W,
    parameter int unsigned DEF_LEN   = tdma_pkg::TDMA_DEF_LEN,
    localparam int unsigned ID_W     = tdma_pkg::idx_width(N_MASTERS)
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [N_MASTERS-1:0] req_i,
    output logic [N_MASTERS-1:0] grant_o,
    output logic                 irq_o,
    input  logic                 cfg_wr_i,
    input  logic [ID_W-1:0]      cfg_id_i,
    input  logic [LEN_W-1:0]     cfg_len_i,
    input  logic                 load_i,
    input  logic [ID_W-1:0]      cfg_rd_id_i,
    output logic [LEN_W-1:0]     cfg_rd_len_o
);
    logic [N_MASTERS-1:0][LEN_W-1:0] act_tbl;
    logic [N_MASTERS-1:0][LEN_W-1:0] pend_nxt;
    logic [ID_W-1:0]                 owner;
    logic                            live;
    logic                            swap;
    logic                            arm_w;

    tdma_slot_table #(
        .N_MASTERS(N_MASTERS), .LEN_W(LEN_W), .DEF_LEN(DEF_LEN)
    ) i_table (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (cfg_wr_i),
        .wr_id_i    (cfg_id_i),
        .wr_len_i   (cfg_len_i),
        .swap_i     (swap),
        .rd_id_i    (cfg_rd_id_i),
        .rd_len_o   (cfg_rd_len_o),
        .act_o      (act_tbl),
        .pend_nxt_o (pend_nxt)
    );

    tdma_wheel_timer #(
        .N_MASTERS(N_MASTERS), .LEN_W(LEN_W), .DEF_LEN(DEF_LEN)
    ) i_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .act_i      (act_tbl),
        .pend_nxt_i (pend_nxt),
        .owner_o    (owner),
        .live_o     (live),
        .swap_o     (swap),
        .arm_o      (arm_w),
        .irq_o      (irq_o)
    );

    tdma_grant_decode #(
        .N_MASTERS(N_MASTERS)
    ) i_grant (
        .owner_i (owner),
        .live_i  (live),
        .req_i   (req_i),
        .grant_o (grant_o)
    );
endmodule

// File: rtl/tdma_wheel_arbiter_chk.sv
module tdma_wheel_arbiter_chk #(
    parameter int unsigned N_MASTERS = tdma_pkg::TDMA_MASTERS,
    parameter int unsigned LEN_W     = tdma_pkg::TDMA_LEN_W,
    localparam int unsigned ID_W     = tdma_pkg::idx_width(N_MASTERS)
) (
    input logic                            clk_i,
    input logic                            rst_ni,
    input logic [N_MASTERS-1:0]            req_i,
    input logic [N_MASTERS-1:0]            grant_o,
    input logic                            irq_o,
    input logic                            cfg_wr_i,
    input logic [ID_W-1:0]                 cfg_id_i,
    input logic [LEN_W-1:0]                cfg_len_i,
    input logic [ID_W-1:0]                 cfg_rd_id_i,
    input logic [LEN_W-1:0]                cfg_rd_len_o,
    input logic                            arm_i,
    input logic [N_MASTERS-1:0][LEN_W-1:0] act_tbl_i
);
    // R10: at most one master holds the bus
    p_grant_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(grant_o));

    // R10: no grant without a request from that master
    p_grant_needs_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o & ~req_i) == '0);

    // R4: a swap notification only follows an armed load
    p_irq_needs_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> $past(arm_i));

    // R4 / R7: the active table changes only together with the interrupt
    p_table_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> $stable(act_tbl_i));

    // R3: the written length is visible at readback in the next cycle
    p_readback_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(cfg_wr_i) && (int'($past(cfg_id_i)) < int'(N_MASTERS))
         && (cfg_rd_id_i == $past(cfg_id_i)))
        |-> (cfg_rd_len_o == $past(cfg_len_i)));
endmodule

bind tdma_wheel_arbiter tdma_wheel_arbiter_chk #(
    .N_MASTERS(N_MASTERS), .LEN_W(LEN_W)
) i_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .grant_o      (grant_o),
    .irq_o        (irq_o),
    .cfg_wr_i     (cfg_wr_i),
    .cfg_id_i     (cfg_id_i),
    .cfg_len_i    (cfg_len_i),
    .cfg_rd_id_i  (cfg_rd_id_i),
    .cfg_rd_len_o (cfg_rd_len_o),
    .arm_i        (arm_w),
    .act_tbl_i    (act_tbl)
);

// File: tb/test_tdma_wheel_arbiter.sv
`timescale 1ns/1ps
module test_tdma_wheel_arbiter;
    localparam int N = 4;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '1;
    logic [N-1:0] grant;
    logic         irq;
    logic         cfg_wr = 1'b0;
    logic [1:0]   cfg_id = '0;
    logic [W-1:0] cfg_len = '0;
    logic         load = 1'b0;
    logic [1:0]   rd_id = '0;
    logic [W-1:0] rd_len;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    tdma_wheel_arbiter #(.N_MASTERS(N), .LEN_W(W), .DEF_LEN(4)) i_tdma_wheel_arbiter (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .grant_o(grant), .irq_o(irq),
        .cfg_wr_i(cfg_wr), .cfg_id_i(cfg_id), .cfg_len_i(cfg_len), .load_i(load),
        .cfg_rd_id_i(rd_id), .cfg_rd_len_o(rd_len)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung, actual=%0d expected<=20000 cycles", cycles);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic write_len(input int id, input int len);
        cfg_wr = 1'b1; cfg_id = 2'(id); cfg_len = W'(len);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_load();
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (irq) return;
        end
        check(1'b0, tag, 0, 1);
    endtask

    // Align to the first cycle of master 0 following a master 3 slot.
    task automatic sync_round_start();
        int k;
        k = 0;
        while (!grant[3] && k < 200) begin @(negedge clk); #1; k++; end
        while (!grant[0] && k < 200) begin @(negedge clk); #1; k++; end
        check(k < 200, "R1 sync", k, 0);
    endtask

    // Compare one whole round, cycle by cycle, starting in the current cycle.
    task automatic check_round(input int tbl [4], input logic [N-1:0] rmask,
                               input bit irq_first, input int load_at, input string tag);
        int s;
        int total;
        s = 0;
        total = 0;
        req = rmask;
        for (int m = 0; m < N; m++) total += tbl[m];
        if (total == 0) begin
            for (int k = 0; k < 8; k++) begin
                if (k > 0) @(negedge clk);
                #1;
                check(grant == '0, {tag, " idle grant"}, int'(grant), 0);
                check(irq == ((k == 0) ? irq_first : 1'b0), {tag, " irq"}, int'(irq), (k == 0) ? int'(irq_first) : 0);
            end
        end else begin
            for (int m = 0; m < N; m++) begin
                for (int k = 0; k < tbl[m]; k++) begin
                    logic [N-1:0] exp;
                    if (s > 0) @(negedge clk);
                    #1;
                    exp = (N'(1) << m) & rmask;
                    check(grant == exp, {tag, " grant"}, int'(grant), int'(exp));
                    check(irq == ((s == 0) ? irq_first : 1'b0), {tag, " irq"}, int'(irq), (s == 0) ? int'(irq_first) : 0);
                    load = (s == load_at);
                    s++;
                end
            end
        end
        req = '1;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R11: master 0 holds the first slot, no interrupt, shadow at default
        check(grant == 4'b0001, "R11 reset grant", int'(grant), 1);
        check(irq == 1'b0, "R11 reset irq", int'(irq), 0);
        for (int i = 0; i < N; i++) begin
            rd_id = 2'(i); #0.1;
            check(rd_len == 8'd4, "R11 reset shadow", int'(rd_len), 4);
        end
        check_round('{4, 4, 4, 4}, 4'b1111, 1'b0, -1, "R1 R2 R11");
    endtask

    task automatic t_program_no_load();
        @(negedge clk);
        write_len(1, 2);
        rd_id = 2'd1; #1;
        check(rd_len == 8'd2, "R3 readback m1", int'(rd_len), 2);
        write_len(3, 6);
        rd_id = 2'd3; #1;
        check(rd_len == 8'd6, "R3 readback m3", int'(rd_len), 6);
        // R4: without load the defaults keep running
        sync_round_start();
        check_round('{4, 4, 4, 4}, 4'b1111, 1'b0, -1, "R4 no load");
        @(negedge clk);
        check_round('{4, 4, 4, 4}, 4'b1111, 1'b0, -1, "R4 no load 2");
    endtask

    task automatic t_deferred_swap();
        sync_round_start();
        // load in the third cycle; the round must finish on the old table
        check_round('{4, 4, 4, 4}, 4'b1111, 1'b0, 2, "R4 deferred");
        @(negedge clk);
        // R5: masters 0 and 2 inherit 4; R7: irq only in first cycle
        check_round('{4, 2, 4, 6}, 4'b1111, 1'b1, -1, "R5 R7 new table");
    endtask

    task automatic t_zero_skip();
        @(negedge clk);
        write_len(1, 0);
        pulse_load();
        wait_irq("R8 irq");
        check_round('{4, 0, 4, 6}, 4'b1111, 1'b1, -1, "R8 zero skip");
    endtask

    task automatic t_write_after_arm();
        pulse_load();
        write_len(2, 3);
        wait_irq("R6 irq");
        check_round('{4, 0, 3, 6}, 4'b1111, 1'b1, -1, "R6 late write");
    endtask

    task automatic t_request_mask();
        sync_round_start();
        check_round('{4, 0, 3, 6}, 4'b0100, 1'b0, -1, "R10 mask");
    endtask

    task automatic t_all_zero();
        @(negedge clk);
        for (int i = 0; i < N; i++) write_len(i, 0);
        pulse_load();
        wait_irq("R9 irq");
        check_round('{0, 0, 0, 0}, 4'b1111, 1'b1, -1, "R9 all zero");
        @(negedge clk);
        write_len(0, 5);
        #1;
        check(grant == '0, "R9 no load no grant", int'(grant), 0);
        load = 1'b1;
        @(negedge clk); #1;
        load = 1'b0;
        check(irq == 1'b0, "R9 irq not yet", int'(irq), 0);
        @(negedge clk); #1;
        check(irq == 1'b1, "R9 irq two cycles after load", int'(irq), 1);
        check_round('{5, 0, 0, 0}, 4'b1111, 1'b1, -1, "R9 single slot");
        @(negedge clk);
        check_round('{5, 0, 0, 0}, 4'b1111, 1'b0, -1, "R1 R9 repeat");
    endtask

    initial begin
        t_reset();
        t_program_no_load();
        t_deferred_swap();
        t_zero_skip();
        t_write_after_arm();
        t_request_mask();
        t_all_zero();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule